// File: doc/BRIEF.md
# Ethernet Receive Frame Status Generator

This block follows the control strobes of a byte-wide Ethernet receive stream, one frame at a time. It counts the bytes of the frame and collects error and address-class flags while the frame is running. When the last byte arrives it decides whether the frame is kept or dropped. A kept frame gets a 32-bit status word, which the downstream FIFO appends after the frame data. A dropped frame gets a one-cycle reject pulse, so the FIFO can discard the bytes it has already stored. Bytes reach this block already assembled from the serial line, with bit 0 of each byte being the first bit received on the wire.

A frame is dropped when it is shorter than the runt limit, for example a collision fragment, or when the address filter refuses it. A frame longer than the programmed maximum is not cut short. It is kept whole, it is marked long, and it raises a babbling-receiver event. Three sticky event bits act as interrupt sources: frame received, babbling receiver, and FIFO overrun. Software clears them by writing ones. The interrupt line is the OR of every event bit that its mask bit enables.

Top module: `rx_frame_status`

## Requirements
- R1: One clock after an accepted frame's last byte (`rx_valid && rx_eof`), `st_valid` goes high. `st_word[15:0]` then holds the frame's total byte count, FCS included, and bits [31:25] are zero.
- R2: The flags sampled with the last byte appear in the status word at fixed positions: bit 16 CRC error (`crc_bad`), bit 18 non-octet (`dribble`), bit 21 multicast, bit 22 broadcast, bit 23 promiscuous-miss (`af_promisc`). An `rx_err` strobe on any byte of the frame sets bit 19.
- R3: If the frame length exceeds `max_len`, bit 20 (long) is set, the frame is still accepted with its full length, and event bit 1 (babbling receiver) is set on the same edge as `st_valid`. A frame of exactly `max_len` bytes is not long.
- R4: A frame shorter than RUNT_LEN bytes (64 by default) makes `fifo_reject` high for exactly the one cycle after its last byte, and it produces no status word and no frame-received event.
- R5: A frame whose last byte arrives with `af_accept` low is rejected in the same way as in R4, whatever its length.
- R6: An accepted frame sets event bit 0 (frame received) on the same edge as `st_valid`. `irq` follows a set event bit only while the matching `irq_mask` bit is 1.
- R7: An `rx_ovr` pulse, inside or outside a frame, sets event bit 2 (FIFO error) on the next edge. If the pulse falls inside a frame, that frame's status word has bit 17 set.
- R8: While `ev_wr` is high, each event bit whose `ev_wdata` bit is 1 is cleared on the next edge, unless it is being set on that same edge. Event bits are never cleared in any other way.
- R9: `st_valid` and `st_word` hold until a cycle with `st_ready` high. A frame that ends while an earlier status word is still waiting is discarded without a status word.
- R10: Once the byte count reaches the counter maximum (2^LEN_W-1), it stops there. The status word then reports that maximum with bit 24 (truncated count) and bit 20 set.
- R11: After reset, `st_valid`, `fifo_reject`, `ev_q` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_err | input | 1 | Receive symbol error seen during the frame |
| rx_ovr | input | 1 | Receive FIFO overrun pulse |
| crc_bad | input | 1 | FCS check failed, valid with the last byte |
| dribble | input | 1 | Frame ended on a non-octet boundary, valid with the last byte |
| af_accept | input | 1 | Address filter keeps the frame, valid with the last byte |
| af_bcast | input | 1 | Destination is the broadcast address |
| af_mcast | input | 1 | Destination is a group address |
| af_promisc | input | 1 | Accepted only because of promiscuous mode (no address hit) |
| max_len | input | LEN_W | Programmed maximum frame length in bytes |
| irq_mask | input | 3 | Interrupt enables for event bits 0..2 |
| ev_wr | input | 1 | Write strobe to the event register |
| ev_wdata | input | 3 | Write-one-to-clear data for the event register |
| ev_q | output | 3 | Event register: 0 frame, 1 babbling, 2 FIFO error |
| st_valid | output | 1 | Status word available |
| st_ready | input | 1 | Downstream takes the status word |
| st_word | output | 32 | Frame status word |
| fifo_reject | output | 1 | One-cycle pulse: discard the frame just written |
| irq | output | 1 | Masked interrupt request |

## Verification
A frame's outcome is decided on the edge that takes its last byte. `st_valid`, `st_word`, `fifo_reject` and the frame and babbling event bits all change on that edge, so they are due one cycle after the last byte. An `rx_ovr` pulse and an event write each act on the next edge, and `irq` follows `ev_q` and `irq_mask` with no further delay. The bench drives every input on the falling edge. After the edge that should produce a result, it waits for the next falling edge and samples there, so each check looks at the first cycle in which its result must be visible. Hold behaviour is checked by sampling again several cycles later with `st_ready` held low.

// File: rtl/rfs_pkg.sv
// Package: shared bit positions for the receive frame status logic.
// Assumes a 32-bit status word with the length held in the low half.
package rfs_pkg;
    localparam int ST_W      = 32;
    localparam int LEN_FIELD = 16;
    localparam int FL_CRC    = 16;
    localparam int FL_OVR    = 17;
    localparam int FL_NONOCT = 18;
    localparam int FL_SYMERR = 19;
    localparam int FL_LONG   = 20;
    localparam int FL_MCAST  = 21;
    localparam int FL_BCAST  = 22;
    localparam int FL_MISS   = 23;
    localparam int FL_TRUNC  = 24;
    localparam int EV_W      = 3;
    localparam int EV_FRAME  = 0;
    localparam int EV_BABR   = 1;
    localparam int EV_FIFO   = 2;
endpackage

// File: rtl/rfs_len_counter.sv
// Module: saturating byte counter for the frame in progress.
// Gives the length including the current byte and a saturation flag.
// Assumes rx_sof is only meaningful together with rx_valid.
module rfs_len_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    output logic [LEN_W-1:0] len_now,
    output logic             sat_now
);
    localparam logic [LEN_W-1:0] CNT_MAX = '1;
    localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

    logic [LEN_W-1:0] cnt_q;
    logic             sat_q;

    // Purpose: record the count after each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sat_q <= 1'b0;
        end else if (rx_valid) begin
            cnt_q <= len_now;
            sat_q <= sat_now;
        end
    end

    // Purpose: compute the length with the current byte counted.
    always_comb begin
        if (rx_sof) begin
            len_now = CNT_ONE;
            sat_now = 1'b0;
        end else if (cnt_q == CNT_MAX) begin
            len_now = CNT_MAX;
            sat_now = 1'b1;
        end else begin
            len_now = cnt_q + CNT_ONE;
            sat_now = sat_q;
        end
    end
endmodule

// File: rtl/rfs_frame_judge.sv
// Module: end-of-frame decision and status word holder.
// Collects sticky error flags during the frame, decides accept or reject
// on the last byte, and holds the status word until it is taken.
// Assumes the address filter flags are valid with the last byte.
module rfs_frame_judge
    import rfs_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int RUNT_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             rx_err,
    input  logic             rx_ovr,
    input  logic             crc_bad,
    input  logic             dribble,
    input  logic             af_accept,
    input  logic             af_bcast,
    input  logic             af_mcast,
    input  logic             af_promisc,
    input  logic [LEN_W-1:0] max_len,
    input  logic [LEN_W-1:0] len_now,
    input  logic             sat_now,
    input  logic             st_ready,
    output logic             st_valid,
    output logic [ST_W-1:0]  st_word,
    output logic             fifo_reject,
    output logic             frame_set,
    output logic             babr_set
);
    localparam logic [LEN_W-1:0] RUNT_L = RUNT_LEN[LEN_W-1:0];

    logic            err_q, ovr_q;
    logic            err_now, ovr_now;
    logic            last_byte, is_long, is_runt, drop;
    logic [ST_W-1:0] word_next;

    // Purpose: sticky error and overrun flags, restarted on a first byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            err_q <= err_now;
            ovr_q <= ovr_now;
        end
    end

    // Purpose: frame-level decision terms for the current cycle.
    always_comb begin
        err_now   = ((rx_valid && rx_sof) ? 1'b0 : err_q) | rx_err;
        ovr_now   = ((rx_valid && rx_sof) ? 1'b0 : ovr_q) | rx_ovr;
        last_byte = rx_valid && rx_eof;
        is_long   = sat_now || (len_now > max_len);
        is_runt   = len_now < RUNT_L;
        drop      = !af_accept || is_runt;
        frame_set = last_byte && !drop && (!st_valid || st_ready);
        babr_set  = last_byte && !drop && is_long;
    end

    // Purpose: assemble the status word from length and flags.
    always_comb begin
        word_next            = '0;
        word_next[LEN_FIELD-1:0] = LEN_FIELD'(len_now);
        word_next[FL_CRC]    = crc_bad;
        word_next[FL_OVR]    = ovr_now;
        word_next[FL_NONOCT] = dribble;
        word_next[FL_SYMERR] = err_now;
        word_next[FL_LONG]   = is_long;
        word_next[FL_MCAST]  = af_mcast;
        word_next[FL_BCAST]  = af_bcast;
        word_next[FL_MISS]   = af_promisc;
        word_next[FL_TRUNC]  = sat_now;
    end

    // Purpose: hold the status word and issue the reject pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid    <= 1'b0;
            st_word     <= '0;
            fifo_reject <= 1'b0;
        end else begin
            fifo_reject <= last_byte && drop;
            if (frame_set) begin
                st_valid <= 1'b1;
                st_word  <= word_next;
            end else if (st_ready) begin
                st_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rfs_event_reg.sv
// Module: sticky event register with write-one-to-clear.
// A set on the same edge as a clear wins.
module rfs_event_reg #(
    parameter int EV_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] ev_set,
    input  logic            ev_wr,
    input  logic [EV_W-1:0] ev_wdata,
    output logic [EV_W-1:0] ev_q
);
    logic [EV_W-1:0] clr;

    // Purpose: select the bits that software clears this cycle.
    always_comb clr = ev_wr ? ev_wdata : '0;

    // Purpose: update each event bit; setting has priority over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= (ev_q & ~clr) | ev_set;
    end
endmodule

// File: rtl/rx_frame_status.sv
// Module: receive frame status generator (top).
// Joins the byte counter, the frame judge and the event register, and
// drives the masked interrupt line.
// Assumes frames do not overlap and bytes arrive already assembled.
module rx_frame_status
    import rfs_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int RUNT_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             rx_err,
    input  logic             rx_ovr,
    input  logic             crc_bad,
    input  logic             dribble,
    input  logic             af_accept,
    input  logic             af_bcast,
    input  logic             af_mcast,
    input  logic             af_promisc,
    input  logic [LEN_W-1:0] max_len,
    input  logic [2:0]       irq_mask,
    input  logic             ev_wr,
    input  logic [2:0]       ev_wdata,
    output logic [2:0]       ev_q,
    output logic             st_valid,
    input  logic             st_ready,
    output logic [31:0]      st_word,
    output logic             fifo_reject,
    output logic             irq
);
    logic [LEN_W-1:0] len_now;
    logic             sat_now, frame_set, babr_set;
    logic [EV_W-1:0]  ev_set;

    rfs_len_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .len_now(len_now), .sat_now(sat_now)
    );

    rfs_frame_judge #(.LEN_W(LEN_W), .RUNT_LEN(RUNT_LEN)) u_judge (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_err(rx_err), .rx_ovr(rx_ovr), .crc_bad(crc_bad),
        .dribble(dribble), .af_accept(af_accept), .af_bcast(af_bcast),
        .af_mcast(af_mcast), .af_promisc(af_promisc), .max_len(max_len),
        .len_now(len_now), .sat_now(sat_now), .st_ready(st_ready),
        .st_valid(st_valid), .st_word(st_word), .fifo_reject(fifo_reject),
        .frame_set(frame_set), .babr_set(babr_set)
    );

    // Purpose: gather the event sources into one set vector.
    always_comb begin
        ev_set           = '0;
        ev_set[EV_FRAME] = frame_set;
        ev_set[EV_BABR]  = babr_set;
        ev_set[EV_FIFO]  = rx_ovr;
    end

    rfs_event_reg #(.EV_W(EV_W)) u_ev (
        .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .ev_wr(ev_wr),
        .ev_wdata(ev_wdata), .ev_q(ev_q)
    );

    // Purpose: raise the interrupt for any enabled pending event.
    always_comb irq = |(ev_q & irq_mask);
endmodule

// File: rtl/rfs_chk.sv
// Module: assertion checker for rx_frame_status, attached by bind.
module rfs_chk #(
    parameter int LEN_W    = 16,
    parameter int RUNT_LEN = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_valid,
    input logic        rx_eof,
    input logic        rx_ovr,
    input logic        ev_wr,
    input logic [2:0]  ev_wdata,
    input logic [2:0]  ev_q,
    input logic        st_valid,
    input logic        st_ready,
    input logic [31:0] st_word,
    input logic        fifo_reject
);
    // R4
    reject_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_valid) |-> !fifo_reject);

    // R9
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_word)));

    // R6
    frame_event_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_q[0]) |-> $past(rx_valid && rx_eof));

    // R3
    babr_event_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_q[1]) |-> $past(rx_valid && rx_eof));

    // R7
    fifo_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |=> ev_q[2]);

    // R8
    w1c_only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(ev_q) & ~ev_q)) |-> $past(ev_wr));

    // R1
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_word[31:25] == 7'd0));

    // R4
    status_not_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (int'(st_word[15:0]) >= RUNT_LEN));
endmodule

bind rx_frame_status rfs_chk #(.LEN_W(LEN_W), .RUNT_LEN(RUNT_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eof(rx_eof),
    .rx_ovr(rx_ovr), .ev_wr(ev_wr), .ev_wdata(ev_wdata), .ev_q(ev_q),
    .st_valid(st_valid), .st_ready(st_ready), .st_word(st_word),
    .fifo_reject(fifo_reject)
);

// File: tb/sim_rx_frame_status.sv
// Directed bench for rx_frame_status; each task checks its own results.
module sim_rx_frame_status;
    localparam int LW = 8;
    localparam int RL = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0, rx_ovr = 0;
    logic          crc_bad = 0, dribble = 0;
    logic          af_accept = 0, af_bcast = 0, af_mcast = 0, af_promisc = 0;
    logic [LW-1:0] max_len = 8'd200;
    logic [2:0]    irq_mask = 3'b000;
    logic          ev_wr = 0;
    logic [2:0]    ev_wdata = 3'b000;
    logic [2:0]    ev_q;
    logic          st_valid, st_ready = 0, fifo_reject, irq;
    logic [31:0]   st_word;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rx_frame_status #(.LEN_W(LW), .RUNT_LEN(RL)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_err(rx_err), .rx_ovr(rx_ovr), .crc_bad(crc_bad),
        .dribble(dribble), .af_accept(af_accept), .af_bcast(af_bcast),
        .af_mcast(af_mcast), .af_promisc(af_promisc), .max_len(max_len),
        .irq_mask(irq_mask), .ev_wr(ev_wr), .ev_wdata(ev_wdata), .ev_q(ev_q),
        .st_valid(st_valid), .st_ready(st_ready), .st_word(st_word),
        .fifo_reject(fifo_reject), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one frame; returns at the falling edge after the last byte.
    task automatic send(input int n, input bit acc, input bit bc, input bit mc,
                        input bit pr, input bit crc, input bit drb,
                        input int err_at, input int ovr_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid   = 1'b1;
            rx_sof     = (i == 0);
            rx_eof     = (i == n - 1);
            rx_err     = (i == err_at);
            rx_ovr     = (i == ovr_at);
            af_accept  = (i == n - 1) && acc;
            af_bcast   = (i == n - 1) && bc;
            af_mcast   = (i == n - 1) && mc;
            af_promisc = (i == n - 1) && pr;
            crc_bad    = (i == n - 1) && crc;
            dribble    = (i == n - 1) && drb;
        end
        @(negedge clk);
        {rx_valid, rx_sof, rx_eof, rx_err, rx_ovr} = '0;
        {af_accept, af_bcast, af_mcast, af_promisc, crc_bad, dribble} = '0;
    endtask

    task automatic drain_and_clear();
        st_ready = 1'b1; ev_wr = 1'b1; ev_wdata = 3'b111;
        @(negedge clk);
        st_ready = 1'b0; ev_wr = 1'b0; ev_wdata = 3'b000;
    endtask

    task automatic t_reset();
        chk("R11 st_valid", {31'd0, st_valid}, 32'd0);
        chk("R11 fifo_reject", {31'd0, fifo_reject}, 32'd0);
        chk("R11 ev_q", {29'd0, ev_q}, 32'd0);
        chk("R11 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_basic();
        send(100, 1, 0, 1, 0, 0, 0, -1, -1);
        chk("R1 st_valid", {31'd0, st_valid}, 32'd1);
        chk("R1 R2 word mcast len100", st_word, 32'd100 | (32'd1 << 21));
        chk("R6 frame event", {29'd0, ev_q}, 32'd1);
        chk("R6 irq masked", {31'd0, irq}, 32'd0);
        irq_mask = 3'b001;
        #1;
        chk("R6 irq enabled", {31'd0, irq}, 32'd1);
        irq_mask = 3'b110;
        #1;
        chk("R6 irq other mask", {31'd0, irq}, 32'd0);
        irq_mask = 3'b000;
        repeat (3) @(negedge clk);
        chk("R9 hold valid", {31'd0, st_valid}, 32'd1);
        chk("R9 hold word", st_word, 32'd100 | (32'd1 << 21));
        // R9: second frame while the first status still waits is discarded
        send(70, 1, 1, 0, 0, 0, 0, -1, -1);
        chk("R9 old word kept", st_word, 32'd100 | (32'd1 << 21));
        // R8: clear only bit 1 (not set) leaves bit 0
        ev_wr = 1'b1; ev_wdata = 3'b010;
        @(negedge clk);
        ev_wr = 1'b0; ev_wdata = 3'b000;
        chk("R8 unwritten bit stays", {29'd0, ev_q}, 32'd1);
        st_ready = 1'b1;
        @(negedge clk);
        st_ready = 1'b0;
        chk("R9 taken", {31'd0, st_valid}, 32'd0);
        ev_wr = 1'b1; ev_wdata = 3'b001;
        @(negedge clk);
        ev_wr = 1'b0; ev_wdata = 3'b000;
        chk("R8 w1c clears", {29'd0, ev_q}, 32'd0);
    endtask

    task automatic t_flags();
        send(64, 1, 1, 0, 1, 1, 1, 5, -1);
        chk("R2 flags len64", st_word,
            32'd64 | (32'd1 << 16) | (32'd1 << 18) | (32'd1 << 19) |
            (32'd1 << 22) | (32'd1 << 23));
        chk("R4 boundary 64 kept", {31'd0, fifo_reject}, 32'd0);
        drain_and_clear();
    endtask

    task automatic t_runt();
        send(63, 1, 0, 0, 0, 0, 0, -1, -1);
        chk("R4 runt reject", {31'd0, fifo_reject}, 32'd1);
        chk("R4 runt no status", {31'd0, st_valid}, 32'd0);
        chk("R4 runt no event", {29'd0, ev_q}, 32'd0);
        @(negedge clk);
        chk("R4 reject one cycle", {31'd0, fifo_reject}, 32'd0);
    endtask

    task automatic t_addr_reject();
        send(150, 0, 0, 1, 0, 0, 0, -1, -1);
        chk("R5 addr reject", {31'd0, fifo_reject}, 32'd1);
        chk("R5 no status", {31'd0, st_valid}, 32'd0);
        chk("R5 no event", {29'd0, ev_q}, 32'd0);
    endtask

    task automatic t_long();
        max_len = 8'd100;
        send(100, 1, 0, 0, 0, 0, 0, -1, -1);
        chk("R3 at max not long", st_word, 32'd100);
        chk("R3 at max no babr", {29'd0, ev_q}, 32'd1);
        drain_and_clear();
        send(101, 1, 0, 0, 0, 0, 0, -1, -1);
        chk("R3 long word", st_word, 32'd101 | (32'd1 << 20));
        chk("R3 long kept", {31'd0, fifo_reject}, 32'd0);
        chk("R3 babr event", {29'd0, ev_q}, 32'd3);
        drain_and_clear();
        max_len = 8'd200;
    endtask

    task automatic t_ovr();
        send(70, 1, 0, 0, 0, 0, 0, -1, 10);
        chk("R7 ovr flag", st_word, 32'd70 | (32'd1 << 17));
        chk("R7 fifo event", {29'd0, ev_q}, 32'd5);
        drain_and_clear();
        @(negedge clk);
        rx_ovr = 1'b1;
        @(negedge clk);
        rx_ovr = 1'b0;
        chk("R7 ovr outside frame", {29'd0, ev_q}, 32'd4);
        drain_and_clear();
    endtask

    task automatic t_sat();
        max_len = 8'd255;
        send(300, 1, 0, 0, 0, 0, 0, -1, -1);
        chk("R10 saturated", st_word, 32'd255 | (32'd1 << 20) | (32'd1 << 24));
        drain_and_clear();
        max_len = 8'd200;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_flags();
        t_runt();
        t_addr_reject();
        t_long();
        t_ovr();
        t_sat();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule